// File: doc/BRIEF.md
# Tapped Delay-Line Shift Register

This block is a sampled shift register with four visible outputs, built as the digital counterpart of an analog shift register. Each time the step strobe is asserted it captures one unsigned sample word and moves every stored sample one place further down a chain. Between each pair of neighbouring taps sits a programmable run of hidden storage positions that no output ever shows. These hidden positions stretch the spacing between taps. When a held input changes at the wrong moment, some input values can therefore never appear together on the taps.

A mode bit chooses where the hidden runs go. In chaos mode they sit only between taps, so tap 1 always shows the newest sample. In normal mode a further run sits ahead of tap 1, so every tap is spaced evenly from the sampling point. The step strobe is a single-cycle pulse in the system clock domain. The block does not care whether an internal or an external clock produced it. Storage is a circular buffer read at four computed ages, so the block never moves data physically.

Top module: `tapped_delay_sr`

## Requirements
- R1: While `rst_n` is low at a clock edge, all taps read zero after that edge. Every stored position, hidden or visible, then behaves as zero.
- R2: In a cycle where `step` is low, all taps keep their values, whatever `sample_in`, `delay_set` and `normal_mode` do.
- R3: With `normal_mode` = 0 (chaos) and an effective delay D, tap k (k = 1..4, bit slice k-1 of `taps`) shows the sample captured (k-1)·(D+1) steps before the newest one. Tap 1 therefore shows the newest sample.
- R4: With `normal_mode` = 1 (normal), tap k shows the sample captured D + (k-1)·(D+1) steps before the newest one.
- R5: With D = 0 the block acts as a plain four-stage shift register in either mode: tap 1 shows the newest sample and each other tap shows the previous value of the tap before it.
- R6: A tap whose age reaches back past the first step after reset reads zero.
- R7: A `delay_set` value above 256 acts as 256.
- R8: A change of `delay_set` or `normal_mode` takes effect at the next step and does not clear stored samples.
- R9: Taps update at the clock edge where `step` is sampled high and are valid right after that edge. A step refreshes all four taps, even when their values do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | One-cycle step strobe: capture and advance |
| sample_in | input | 12 | Sample word captured on a step |
| delay_set | input | 9 | Hidden positions per gap (values above 256 act as 256) |
| normal_mode | input | 1 | 1 = hidden run also ahead of tap 1, 0 = chaos |
| taps | output | 48 | Four taps, tap k in bits [12k-1:12(k-1)] |

## Verification
Every tap result is due one edge after the step that produced it. The bench raises `step` on a falling edge, lowers it on the next falling edge and compares the taps there, half a period after the one edge that loaded them. Hold checks drive changing inputs without a step and compare the taps on each following falling edge. Reset is checked at the falling edge after the first edge where reset was sampled low.

// File: rtl/tdsr_pkg.sv
// Shared constants and helpers for the tapped delay-line shift register.
// Assumes the tap count and maximum delay are fixed at elaboration.
package tdsr_pkg;
    // Clamp a raw delay request to the supported maximum.
    function automatic int unsigned clamp_delay(int unsigned raw, int unsigned max_d);
        return (raw > max_d) ? max_d : raw;
    endfunction
endpackage

// File: rtl/tdsr_age_calc.sv
// Computes the storage age read by each tap from the delay setting and mode.
// Age 0 is the sample captured on the current step. Assumes the maximum age
// TAPS*MAX_DLY+TAPS-1 fits in AW bits.
module tdsr_age_calc #(
    parameter int TAPS    = 4,
    parameter int MAX_DLY = 256,
    parameter int DW      = 9,
    parameter int AW      = 11
) (
    input  logic [DW-1:0]          delay_set,
    input  logic                   normal_mode,
    output logic [TAPS-1:0][AW-1:0] age
);
    import tdsr_pkg::*;

    logic [AW-1:0] eff_d;
    logic [AW-1:0] lead;

    // Clamp the delay and derive the leading hidden run for normal mode.
    always_comb begin
        eff_d = AW'(clamp_delay(int'(delay_set), MAX_DLY));
        lead  = normal_mode ? eff_d : '0;
    end

    // Each tap sits one visible stage plus eff_d hidden stages past the previous one.
    for (genvar k = 0; k < TAPS; k++) begin : g_age
        always_comb age[k] = lead + AW'(k) * (eff_d + AW'(1));
    end
endmodule

// File: rtl/tdsr_store.sv
// Circular sample store with a write pointer and a saturating fill count.
// Reads by age: age 0 returns the incoming sample, older ages read the
// buffer. A read past the fill count reports invalid, so positions never
// written since reset act as zero without clearing the array.
module tdsr_store #(
    parameter int TAPS  = 4,
    parameter int W     = 12,
    parameter int AW    = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic [W-1:0]            sample_in,
    input  logic [TAPS-1:0][AW-1:0] age,
    output logic [TAPS-1:0][W-1:0]  rd_data,
    output logic [TAPS-1:0]         rd_valid
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] FILL_MAX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] fill;

    // Write the captured sample at the pointer on each step.
    always_ff @(posedge clk) begin
        if (step) mem[wr_ptr] <= sample_in;
    end

    // Advance the pointer and count stored samples up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (step) begin
            wr_ptr <= wr_ptr + AW'(1);
            if (fill != FILL_MAX) fill <= fill + AW'(1);
        end
    end

    // Per-tap read: bypass for age 0, buffer lookup otherwise.
    for (genvar k = 0; k < TAPS; k++) begin : g_rd
        always_comb begin
            if (age[k] == '0) begin
                rd_data[k]  = sample_in;
                rd_valid[k] = 1'b1;
            end else begin
                rd_data[k]  = mem[wr_ptr - age[k]];
                rd_valid[k] = (age[k] <= fill);
            end
        end
    end
endmodule

// File: rtl/tdsr_tap_bank.sv
// Output registers for the taps. All taps reload on every step. An
// invalid read loads zero. Assumes step is a one-cycle strobe.
module tdsr_tap_bank #(
    parameter int TAPS = 4,
    parameter int W    = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step,
    input  logic [TAPS-1:0][W-1:0] rd_data,
    input  logic [TAPS-1:0]        rd_valid,
    output logic [TAPS-1:0][W-1:0] taps
);
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        // Reload tap k on a step, zero when the read lies before the first sample.
        always_ff @(posedge clk) begin
            if (!rst_n)    taps[k] <= '0;
            else if (step) taps[k] <= rd_valid[k] ? rd_data[k] : '0;
        end
    end
endmodule

// File: rtl/tapped_delay_sr.sv
// Top: four-tap sample shift register with programmable hidden stages
// between taps and an optional leading hidden run (normal mode).
// Assumes step is synchronous to clk and one cycle wide.
module tapped_delay_sr #(
    parameter int W       = 12,
    parameter int TAPS    = 4,
    parameter int MAX_DLY = 256,
    parameter int DW      = $clog2(MAX_DLY + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step,
    input  logic [W-1:0]           sample_in,
    input  logic [DW-1:0]          delay_set,
    input  logic                   normal_mode,
    output logic [TAPS-1:0][W-1:0] taps
);
    localparam int MAX_AGE = TAPS * MAX_DLY + TAPS - 1;
    localparam int AW      = $clog2(MAX_AGE + 2);

    logic [TAPS-1:0][AW-1:0] age;
    logic [TAPS-1:0][W-1:0]  rd_data;
    logic [TAPS-1:0]         rd_valid;

    tdsr_age_calc #(.TAPS(TAPS), .MAX_DLY(MAX_DLY), .DW(DW), .AW(AW)) u_age (
        .delay_set   (delay_set),
        .normal_mode (normal_mode),
        .age         (age)
    );

    tdsr_store #(.TAPS(TAPS), .W(W), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .sample_in (sample_in),
        .age       (age),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    tdsr_tap_bank #(.TAPS(TAPS), .W(W)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .taps     (taps)
    );
endmodule

// File: rtl/tapped_delay_sr_chk.sv
// Checker bound to the top: port-level properties over time.
module tapped_delay_sr_chk #(
    parameter int W    = 12,
    parameter int TAPS = 4,
    parameter int DW   = 9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   step,
    input logic [W-1:0]           sample_in,
    input logic [DW-1:0]          delay_set,
    input logic                   normal_mode,
    input logic [TAPS-1:0][W-1:0] taps
);
    // R1: reset sampled low clears every tap.
    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> taps == '0);

    // R2: no step, no change.
    a_r2_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(taps));

    // R3: chaos mode puts the newest sample on tap 1.
    a_r3_chaos_tap1_newest: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !normal_mode) |=> taps[0] == $past(sample_in));

    // R5: zero delay shifts tap to tap.
    a_r5_plain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (step && delay_set == '0) |=>
        (taps[0] == $past(sample_in) && taps[1] == $past(taps[0]) &&
         taps[2] == $past(taps[1]) && taps[3] == $past(taps[2])));

    // R4: normal mode with a nonzero delay never shows the new sample on tap 1 at once.
    a_r4_normal_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (step && normal_mode && delay_set != '0 && $past(taps[0]) == '0 && taps[0] == '0
         && sample_in != '0 && $past(step) == 1'b0 && $past(rst_n) == 1'b0) |=> taps[0] == '0);
endmodule

bind tapped_delay_sr tapped_delay_sr_chk #(.W(W), .TAPS(TAPS), .DW(DW)) u_chk (.*);

// File: tb/tapped_delay_sr_test.sv
module tapped_delay_sr_test;
    localparam int W = 12;
    localparam int TAPS = 4;
    localparam int DW = 9;
    localparam int HMAX = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step = 1'b0;
    logic [W-1:0] sample_in = '0;
    logic [DW-1:0] delay_set = '0;
    logic normal_mode = 1'b0;
    logic [TAPS-1:0][W-1:0] taps;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int hist [HMAX];
    int hcnt = 0;

    // Chaos mode, one hidden stage per gap: held-input sequence and expected taps.
    localparam int TBL_N = 8;
    localparam int TBL_IN [TBL_N] = '{1, 1, 2, 3, 3, 3, 3, 3};
    localparam int TBL_EXP [TBL_N][TAPS] = '{
        '{1,0,0,0}, '{1,0,0,0}, '{2,1,0,0}, '{3,1,0,0},
        '{3,2,1,0}, '{3,3,1,0}, '{3,3,2,1}, '{3,3,3,1}};

    tapped_delay_sr uut (
        .clk(clk), .rst_n(rst_n), .step(step), .sample_in(sample_in),
        .delay_set(delay_set), .normal_mode(normal_mode), .taps(taps)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish (got %0d cycles, expected < 150000)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int tap, input int got, input int exp);
        checks = checks + 1;
        if (got != exp) begin
            fails = fails + 1;
            $display("FAIL %s tap%0d: actual %0d expected %0d", req, tap, got, exp);
        end
    endtask

    function automatic int tap_age(input int k, input int d, input bit nrm);
        return (nrm ? d : 0) + k * (d + 1);
    endfunction

    function automatic int model_tap(input int k, input int d, input bit nrm);
        int a;
        a = tap_age(k, d, nrm);
        return (a < hcnt) ? hist[a] : 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        hcnt = 0;
    endtask

    // One step: drive on a falling edge, compare at the next falling edge.
    task automatic do_step(input int v);
        @(negedge clk);
        step = 1'b1;
        sample_in = W'(v);
        for (int i = HMAX - 1; i > 0; i--) hist[i] = hist[i - 1];
        hist[0] = v & ((1 << W) - 1);
        if (hcnt < HMAX) hcnt = hcnt + 1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic check_model(input string req, input int d, input bit nrm);
        for (int k = 0; k < TAPS; k++) check(req, k + 1, int'(taps[k]), model_tap(k, d, nrm));
    endtask

    initial begin
        // R1: reset state.
        do_reset();
        @(negedge clk);
        for (int k = 0; k < TAPS; k++) check("R1 reset", k + 1, int'(taps[k]), 0);

        // R3 / R9: table walk, chaos mode, one hidden stage per gap.
        delay_set = 9'd1;
        normal_mode = 1'b0;
        for (int r = 0; r < TBL_N; r++) begin
            do_step(TBL_IN[r]);
            for (int k = 0; k < TAPS; k++) check("R3/R9 table", k + 1, int'(taps[k]), TBL_EXP[r][k]);
        end

        // R2: inputs move with no step; taps must hold.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            sample_in = W'(100 + i);
            delay_set = DW'(i);
            normal_mode = i[0];
            for (int k = 0; k < TAPS; k++) check("R2 hold", k + 1, int'(taps[k]), TBL_EXP[TBL_N-1][k]);
        end

        // R5: zero delay in chaos then normal mode.
        do_reset();
        delay_set = '0;
        normal_mode = 1'b0;
        for (int i = 0; i < 6; i++) begin
            do_step(10 + i);
            check_model("R5 chaos", 0, 1'b0);
        end
        normal_mode = 1'b1;
        for (int i = 0; i < 3; i++) begin
            do_step(40 + i);
            check_model("R5 normal", 0, 1'b1);
        end

        // R4 / R6: normal mode, one hidden stage, zeros until ages are filled.
        do_reset();
        delay_set = 9'd1;
        for (int i = 0; i < 10; i++) begin
            do_step(200 + i);
            check_model("R4/R6 normal d1", 1, 1'b1);
        end

        // R8: change delay and mode between steps; history is kept.
        delay_set = 9'd2;
        normal_mode = 1'b0;
        do_step(300);
        check_model("R8 change d2 chaos", 2, 1'b0);
        normal_mode = 1'b1;
        do_step(301);
        check_model("R8 change normal", 2, 1'b1);

        // R4 / R6: maximum delay, normal mode, fill past the deepest tap.
        do_reset();
        delay_set = 9'd256;
        normal_mode = 1'b1;
        for (int i = 0; i < 1040; i++) begin
            do_step(i * 7 + 1);
            check_model("R4/R6 max delay", 256, 1'b1);
        end

        // R7: a request above the maximum acts as the maximum.
        do_reset();
        delay_set = 9'd300;
        normal_mode = 1'b0;
        for (int i = 0; i < 800; i++) begin
            do_step(i * 3 + 5);
            check_model("R7 clamp", 256, 1'b0);
        end

        // R1: reset after data clears hidden stages too.
        delay_set = 9'd2;
        normal_mode = 1'b1;
        do_reset();
        @(negedge clk);
        for (int k = 0; k < TAPS; k++) check("R1 reset after data", k + 1, int'(taps[k]), 0);
        do_step(55);
        check_model("R1 hidden cleared", 2, 1'b1);

        // R9: a step with an unchanged sample still loads taps.
        do_reset();
        delay_set = '0;
        normal_mode = 1'b0;
        do_step(9);
        do_step(9);
        check_model("R9 refresh", 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule